// File: doc/BRIEF.md
# Memory Region Access Filter

This block sits on the path between the agents of a chip and its memory and decides, access by access, whether the requester may touch the addressed location. It holds a parameterised set of protected windows, eight by default. Each window has a lower and an upper bound in kilobyte units and two 32-bit permission masks, one for reads and one for writes. Each bit position in a mask stands for one requesting agent. A small register port programs the windows. A window can be frozen by a sticky lock that only a block reset removes.

Each access presents an address, a direction flag and a one-hot agent code. The filter answers in the same cycle. A refused write never reaches memory, and a refused read has its data replaced with all ones. One cycle after a refusal the block raises a single-cycle reset request for the system. Addresses that fall in no active window always pass.

Top module: `mem_region_guard`

## Requirements
- R1: After reset, every window reads back lower and upper words as 0, read mask as 0xBFFFFFFF and write mask as 0xFFFFFFFF, and reset_req is low.
- R2: Window i occupies register words REG_BASE+4*i+k with k=0 lower bound, k=1 upper bound, k=2 read mask, k=3 write mask (REG_BASE=0x40 by default). Any other register address reads 0, and writes to it change nothing.
- R3: Bound words keep only bits 24:2 as the kilobyte number. Bits 30:25 and 1:0 read as 0. Bit 31 reads 0 in the upper bound word.
- R4: A window is active only when both its lower and its upper kilobyte numbers are nonzero. An inactive window never refuses an access.
- R5: An access at byte address A hits an active window when lower <= A[31:10] <= upper. The window therefore covers bytes lower*1024 through upper*1024+0x3FF.
- R6: A hit read is allowed only when read_mask & agent is nonzero, and a hit write only when write_mask & agent is nonzero. The agent code is one-hot, and the masks use these bit positions: 31 flush engine, 30 snooping CPU, 29 host bridge, 15:12 second virtual channel IDs 3..0, 11:8 first virtual channel IDs 3..0, 1 CPU in management mode, 0 CPU in normal mode.
- R7: mem_we is high in the cycle of a valid allowed write and low for any refused or invalid access.
- R8: For a read, txn_rdata equals mem_rdata when allowed and 0xFFFFFFFF when refused.
- R9: reset_req is high for exactly the cycle after each valid refused access and low otherwise.
- R10: Writing the lower bound word with bit 31 set sets the window's lock and leaves its address field unchanged. The lock reads back in bit 31.
- R11: While a window is locked, writes to all four of its words are ignored, and other windows stay writable. Only a block reset clears the lock.
- R12: When active windows overlap, an access must be permitted by every window it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_we | input | 1 | Register write strobe |
| cfg_rdata | output | 32 | Register read data, combinational |
| txn_valid | input | 1 | Access present |
| txn_addr | input | 32 | Access byte address |
| txn_write | input | 1 | 1 for write, 0 for read |
| txn_agent | input | 32 | One-hot requesting agent code |
| mem_rdata | input | 32 | Read data returned by memory |
| txn_allow | output | 1 | Permission decision for the presented access |
| mem_we | output | 1 | Write forwarded to memory |
| txn_rdata | output | 32 | Read data after substitution |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted bound or mask appears as a wrong txn_allow in the same cycle that an access lands next to a window edge, so the sweep tries both the first and the last byte of each kilobyte around every bound, for all 32 agent bits in both directions. A lost or spurious lock shows only at the register port, in the readback after a write attempt that should or should not have been ignored. A wrong refusal also shows one cycle later on reset_req.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   localparam int WORD_W    = 32;
   localparam int LOCK_BIT  = 31;
   localparam int FIELD_MSB = 24;
   localparam int FIELD_LSB = 2;
   localparam int FIELD_W   = FIELD_MSB - FIELD_LSB + 1;
   localparam int GRAN_LOG2 = 10;
   localparam logic [WORD_W-1:0] RMASK_INIT = 32'hBFFF_FFFF;
   localparam logic [WORD_W-1:0] WMASK_INIT = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      SLOT_LO    = 2'd0,
      SLOT_HI    = 2'd1,
      SLOT_RMASK = 2'd2,
      SLOT_WMASK = 2'd3
   } slot_e;

   typedef logic [FIELD_W-1:0] kb_t;
endpackage

// File: rtl/mrg_region.sv
module mrg_region
   import mrg_pkg::*;
#(
   parameter int CFG_AW = 8,
   parameter int BASE   = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              cfg_we,
   input  kb_t               txn_kb,
   input  logic              txn_write,
   input  logic [WORD_W-1:0] txn_agent,
   output logic [WORD_W-1:0] rd_data,
   output logic              permit
);
   localparam logic [CFG_AW-1:0] BASE_V = CFG_AW'(BASE);

   kb_t               lo_kb, hi_kb;
   logic [WORD_W-1:0] rmask, wmask;
   logic              locked;
   logic              sel, active, hit;
   slot_e             slot;
   logic [WORD_W-1:0] mask;

   assign sel  = (cfg_addr[CFG_AW-1:2] == BASE_V[CFG_AW-1:2]);
   assign slot = slot_e'(cfg_addr[1:0]);

   // Lock freezes all four words; lock itself is set by a separate write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_kb  <= '0;
         hi_kb  <= '0;
         rmask  <= RMASK_INIT;
         wmask  <= WMASK_INIT;
         locked <= 1'b0;
      end else if (cfg_we && sel && !locked) begin
         unique case (slot)
            SLOT_LO: begin
               if (cfg_wdata[LOCK_BIT]) locked <= 1'b1;
               else                     lo_kb  <= cfg_wdata[FIELD_MSB:FIELD_LSB];
            end
            SLOT_HI:    hi_kb <= cfg_wdata[FIELD_MSB:FIELD_LSB];
            SLOT_RMASK: rmask <= cfg_wdata;
            SLOT_WMASK: wmask <= cfg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      if (sel) begin
         unique case (slot)
            SLOT_LO:    rd_data = {locked, 6'b0, lo_kb, 2'b0};
            SLOT_HI:    rd_data = {7'b0, hi_kb, 2'b0};
            SLOT_RMASK: rd_data = rmask;
            SLOT_WMASK: rd_data = wmask;
            default:    rd_data = '0;
         endcase
      end
   end

   assign active = (|lo_kb) && (|hi_kb);
   assign hit    = active && (txn_kb >= lo_kb) && (txn_kb <= hi_kb);
   assign mask   = txn_write ? wmask : rmask;
   assign permit = !hit || (|(mask & txn_agent));
endmodule

// File: rtl/mrg_decide.sv
module mrg_decide
   import mrg_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic [NUM_REGIONS-1:0]             permit,
   input  logic [NUM_REGIONS-1:0][WORD_W-1:0] rd_data,
   output logic                               allow,
   output logic [WORD_W-1:0]                  cfg_rdata
);
   // Every matching window must agree; unselected windows drive zero.
   assign allow = &permit;

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_REGIONS; i++) cfg_rdata = cfg_rdata | rd_data[i];
   end
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
   import mrg_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int CFG_AW      = 8,
   parameter int REG_BASE    = 'h40,
   parameter int ADDR_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              cfg_we,
   output logic [31:0]       cfg_rdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_write,
   input  logic [31:0]       txn_agent,
   input  logic [31:0]       mem_rdata,
   output logic              txn_allow,
   output logic              mem_we,
   output logic [31:0]       txn_rdata,
   output logic              reset_req
);
   localparam int KB_W    = ADDR_W - GRAN_LOG2;
   localparam int MAP_END = REG_BASE + 4 * NUM_REGIONS;

   if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_count
      $error("NUM_REGIONS out of range");
   end
   if ((REG_BASE % 4) != 0) begin : g_bad_base
      $error("REG_BASE must be word-group aligned");
   end
   if (MAP_END > (1 << CFG_AW)) begin : g_bad_map
      $error("register map exceeds CFG_AW");
   end
   if (KB_W < 1 || KB_W > FIELD_W) begin : g_bad_addr
      $error("ADDR_W does not fit the bound field");
   end

   kb_t                                txn_kb;
   logic [NUM_REGIONS-1:0]             permit;
   logic [NUM_REGIONS-1:0][WORD_W-1:0] rd_data;
   logic                               allow;
   logic                               unused_offset;

   assign txn_kb        = kb_t'(txn_addr >> GRAN_LOG2);
   assign unused_offset = ^txn_addr[GRAN_LOG2-1:0];

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      mrg_region #(
         .CFG_AW (CFG_AW),
         .BASE   (REG_BASE + 4 * g)
      ) u_region (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_addr  (cfg_addr),
         .cfg_wdata (cfg_wdata),
         .cfg_we    (cfg_we),
         .txn_kb    (txn_kb),
         .txn_write (txn_write),
         .txn_agent (txn_agent),
         .rd_data   (rd_data[g]),
         .permit    (permit[g])
      );
   end

   mrg_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
      .permit    (permit),
      .rd_data   (rd_data),
      .allow     (allow),
      .cfg_rdata (cfg_rdata)
   );

   assign txn_allow = allow;
   assign mem_we    = txn_valid && txn_write && allow;
   assign txn_rdata = allow ? mem_rdata : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reset_req <= 1'b0;
      else        reset_req <= txn_valid && !allow;
   end
endmodule

// File: rtl/mrg_checker.sv
module mrg_checker #(
   parameter int CFG_AW   = 8,
   parameter int REG_BASE = 'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [31:0]       cfg_rdata,
   input logic              txn_valid,
   input logic              txn_write,
   input logic              txn_allow,
   input logic              mem_we,
   input logic [31:0]       txn_rdata,
   input logic              reset_req
);
   localparam logic [CFG_AW-1:0] BASE_V = CFG_AW'(REG_BASE);

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr < BASE_V) |-> (cfg_rdata == 32'h0));

   p_refused_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_write && !txn_allow) |-> !mem_we);

   p_we_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (txn_valid && txn_write));

   p_refused_read_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_write && !txn_allow) |-> (txn_rdata == 32'hFFFF_FFFF));

   p_reset_follows_refusal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_allow) |=> reset_req);

   p_reset_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(txn_valid && !txn_allow));

   p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_addr == BASE_V) && $past(cfg_addr == BASE_V) && $past(cfg_rdata[31]))
      |-> cfg_rdata[31]);
endmodule

bind mem_region_guard mrg_checker #(
   .CFG_AW   (CFG_AW),
   .REG_BASE (REG_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .txn_valid (txn_valid),
   .txn_write (txn_write),
   .txn_allow (txn_allow),
   .mem_we    (mem_we),
   .txn_rdata (txn_rdata),
   .reset_req (reset_req)
);

// File: tb/mem_region_guard_tb.sv
module mem_region_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int BASE       = 'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_rdata;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_write = 1'b0;
   logic [31:0] txn_agent = '0;
   logic [31:0] mem_rdata = '0;
   logic        txn_allow, mem_we, reset_req;
   logic [31:0] txn_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   logic [22:0] m_lo [N];
   logic [22:0] m_hi [N];
   logic [31:0] m_rm [N];
   logic [31:0] m_wm [N];
   logic        m_lk [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_region_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
      .txn_addr(txn_addr), .txn_write(txn_write), .txn_agent(txn_agent),
      .mem_rdata(mem_rdata), .txn_allow(txn_allow), .mem_we(mem_we),
      .txn_rdata(txn_rdata), .reset_req(reset_req)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_lo[i] = '0; m_hi[i] = '0; m_lk[i] = 1'b0;
         m_rm[i] = 32'hBFFF_FFFF; m_wm[i] = 32'hFFFF_FFFF;
      end
   endtask

   function automatic logic [31:0] exp_reg(int a);
      int i, k;
      if (a < BASE || a >= BASE + 4*N) return 32'h0;
      i = (a - BASE) / 4;
      k = (a - BASE) % 4;
      case (k)
         0: return {m_lk[i], 6'b0, m_lo[i], 2'b0};
         1: return {7'b0, m_hi[i], 2'b0};
         2: return m_rm[i];
         default: return m_wm[i];
      endcase
   endfunction

   function automatic logic exp_allow(logic [31:0] addr, logic wr, logic [31:0] agent);
      logic [22:0] kb;
      logic        ok;
      kb = {1'b0, addr[31:10]};
      ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (m_lo[i] != 0 && m_hi[i] != 0 && kb >= m_lo[i] && kb <= m_hi[i]) begin
            if (((wr ? m_wm[i] : m_rm[i]) & agent) == 0) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   task automatic cfg_wr(int a, logic [31:0] d);
      int i, k;
      @(negedge clk);
      cfg_addr = 8'(a); cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a >= BASE && a < BASE + 4*N) begin
         i = (a - BASE) / 4;
         k = (a - BASE) % 4;
         if (!m_lk[i]) begin
            case (k)
               0: if (d[31]) m_lk[i] = 1'b1; else m_lo[i] = d[24:2];
               1: m_hi[i] = d[24:2];
               2: m_rm[i] = d;
               default: m_wm[i] = d;
            endcase
         end
      end
   endtask

   task automatic cfg_rd(int a, string req);
      @(negedge clk);
      cfg_addr = 8'(a);
      #1 check(req, "cfg_rdata", cfg_rdata, exp_reg(a));
   endtask

   task automatic txn(logic [31:0] addr, logic wr, logic [31:0] agent, string req);
      logic a;
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = addr; txn_write = wr; txn_agent = agent;
      mem_rdata = addr ^ 32'hA5A5_0F0F;
      a = exp_allow(addr, wr, agent);
      #1;
      check(req, "txn_allow", 32'(txn_allow), 32'(a));
      if (wr) check("R7", "mem_we", 32'(mem_we), 32'(a));
      else    check("R8", "txn_rdata", txn_rdata, a ? (addr ^ 32'hA5A5_0F0F) : 32'hFFFF_FFFF);
      @(posedge clk);
      #1;
      check("R9", "reset_req", 32'(reset_req), 32'(!a));
      txn_valid = 1'b0;
   endtask

   task automatic sweep_kb(int kb, string req);
      for (int off = 0; off < 2; off++) begin
         for (int b = 0; b < 32; b++) begin
            for (int w = 0; w < 2; w++) begin
               txn((32'(kb) << 10) + (off ? 32'h3FF : 32'h0), w[0], 32'h1 << b, req);
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset contents and quiet reset request
      #1 check("R1", "reset_req", 32'(reset_req), 32'h0);
      for (int a = BASE; a < BASE + 4*N; a++) cfg_rd(a, "R1");

      // R2: unmapped addresses read zero and ignore writes
      cfg_rd('h00, "R2"); cfg_rd('h3C, "R2"); cfg_rd('h60, "R2"); cfg_rd('hFF, "R2");
      cfg_wr('h3C, 32'hFFFF_FFFF);
      cfg_wr('h60, 32'h1234_5678);
      cfg_rd('h3C, "R2"); cfg_rd('h60, "R2"); cfg_rd('h40, "R2"); cfg_rd('h5F, "R2");

      // R3: reserved bits of the bound words
      cfg_wr('h40, 32'h7FFF_FFFF);
      cfg_rd('h40, "R3");
      check("R3", "lo field", exp_reg('h40), 32'h01FF_FFFC);
      cfg_wr('h41, 32'hFFFF_FFFF);
      cfg_rd('h41, "R3");
      cfg_wr('h40, 32'h0); cfg_wr('h41, 32'h0);

      // R4: half-programmed window stays inactive
      cfg_wr('h42, 32'h0); cfg_wr('h43, 32'h0);
      cfg_wr('h40, 32'(4) << 2);
      txn(32'h0000_1000, 1'b0, 32'h1, "R4");
      txn(32'h0000_1C00, 1'b1, 32'h2, "R4");
      cfg_wr('h41, 32'(7) << 2);
      txn(32'h0000_1000, 1'b0, 32'h1, "R4");

      // R5 R6: edges of window 0 for all agents and both directions
      cfg_wr('h42, 32'h0000_0101);
      cfg_wr('h43, 32'h0000_0002);
      sweep_kb(3, "R5"); sweep_kb(4, "R5"); sweep_kb(7, "R6"); sweep_kb(8, "R6");

      // R9: invalid access produces neither write nor reset request
      @(negedge clk);
      txn_valid = 1'b0; txn_addr = 32'h0000_1000; txn_write = 1'b1; txn_agent = 32'h1;
      #1 check("R9", "mem_we idle", 32'(mem_we), 32'h0);
      @(posedge clk); #1 check("R9", "reset_req idle", 32'(reset_req), 32'h0);

      // R12: overlapping window 1
      cfg_wr('h44, 32'(6) << 2);
      cfg_wr('h45, 32'(10) << 2);
      cfg_wr('h46, 32'h0000_0100);
      cfg_wr('h47, 32'hFFFF_FFFF);
      sweep_kb(5, "R12"); sweep_kb(6, "R12"); sweep_kb(10, "R12"); sweep_kb(11, "R12");
      txn(32'hFFFF_FC00, 1'b1, 32'h8000_0000, "R12");

      // R10: lock write keeps the address field
      cfg_wr('h40, 32'h8000_0000);
      cfg_rd('h40, "R10");
      check("R10", "lock readback", exp_reg('h40), 32'h8000_0010);

      // R11: locked window ignores all four words, window 1 stays writable
      cfg_wr('h40, 32'h0000_0000);
      cfg_wr('h41, 32'h0000_0100);
      cfg_wr('h42, 32'hFFFF_FFFF);
      cfg_wr('h43, 32'hFFFF_FFFF);
      for (int a = 'h40; a < 'h44; a++) cfg_rd(a, "R11");
      sweep_kb(4, "R11");
      cfg_wr('h46, 32'h0000_0001);
      cfg_rd('h46, "R11");
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      for (int a = 'h40; a < 'h48; a++) cfg_rd(a, "R11");
      cfg_wr('h40, 32'(8) << 2);
      cfg_rd('h40, "R11");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule